// File: doc/BRIEF.md
# Clear-On-Read Ethernet MAC Statistics Bank

This block holds the statistics counters of one Ethernet MAC port as 32 word registers, each 32 bits wide. Byte offset 4*N holds word N. The receive MAC pulses a frame-done strobe once for each frame. The pulse carries the frame length, a good/bad flag and broadcast/multicast flags. The transmit MAC pulses a strobe once for each frame it sends successfully, with the length and the address-type flags. A vector of single-cycle strobes covers the remaining error and flow-control events. Each good received frame is also counted in one of six length bins.

Software reads a counter by asserting `rd_en` with a word index. The counter value comes back one cycle later on `rd_data`, marked by `rd_valid`, and the read clears the counter. Sweeping all 32 words therefore both collects the statistics and empties the bank. Two octet totals are 64 bits wide and occupy a low/high word pair. Reading the low word takes a snapshot of the high half, and the next read of the high word returns that snapshot. The 64-bit value is therefore always read coherently.

A two-state read machine sequences the port. In `RD_IDLE`, the accept transition moves to `RD_RESP` when `rd_en` is high. From `RD_RESP`, the back-to-back transition stays in `RD_RESP` when `rd_en` is high again. The drain transition returns to `RD_IDLE` when `rd_en` is low. `rd_valid` is high exactly in `RD_RESP`.

Top module: `mac_stats_bank`

## Requirements
- R1: After reset every word reads as zero and `rd_valid` and `rd_data` are low.
- R2: `rd_valid` is high in the cycle after a cycle with `rd_en` high and low otherwise. `rd_data` carries the addressed value when `rd_valid` is high and is zero when it is low.
- R3: A read returns the counter value and clears it, so a second read with no intervening event returns zero.
- R4: An increment in the same cycle as a read of that counter is kept. The read returns the old value and the counter restarts at the increment.
- R5: The 32-bit counters, including the bad-octet count (word 2) and the frame counts, saturate at 0xFFFFFFFF instead of wrapping.
- R6: A good received frame (`rx_done` and `rx_ok`) adds its length to the 64-bit pair words 0 (low) and 1 (high). It adds one to word 4, one to word 6 if `rx_bcast` is high, and one to word 7 if `rx_mcast` is high.
- R7: A good received frame adds one to exactly one length bin. The bins are word 8 for lengths up to 64, word 9 for 65-127, word 10 for 128-255, word 11 for 256-511, word 12 for 512-1023 and word 13 for 1024 and above.
- R8: A bad received frame (`rx_done` with `rx_ok` low) adds its length to word 2 and one to word 5. It touches no good-frame word and no bin.
- R9: Reading low word 0 or 14 copies the high half of its 64-bit total into a snapshot and clears the total. The next read of word 1 or 15 returns the snapshot and clears it. The total carries from the low word into the high word.
- R10: A sent frame (`tx_done`) adds its length to the 64-bit pair words 14 (low) and 15 (high). It adds one to word 16, one to word 18 if `tx_mcast` is high, and one to word 19 if `tx_bcast` is high.
- R11: Bit k of `misc_evt` adds one to a fixed word: bit 0 to word 3, bit 1 to word 17, and bit k (k from 2 to 13) to word 18+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Received frame complete, one cycle |
| rx_len | input | 16 | Received frame length in bytes |
| rx_ok | input | 1 | Received frame is good |
| rx_bcast | input | 1 | Received frame is broadcast |
| rx_mcast | input | 1 | Received frame is multicast |
| tx_done | input | 1 | Frame sent successfully, one cycle |
| tx_len | input | 16 | Sent frame length in bytes |
| tx_bcast | input | 1 | Sent frame is broadcast |
| tx_mcast | input | 1 | Sent frame is multicast |
| misc_evt | input | 14 | Single-increment event strobes |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Word index of the read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The assertions check the read handshake on every cycle: the response timing, the zero data outside a response, and the rule that an immediate reread of an untouched word returns zero. Counter contents can only be shown by the bench's scenarios. These cover the bin boundaries through a length sweep, the saturation and 64-bit carry after about 65 thousand maximum-length frames, the coherence of the snapshot across new traffic, a read that collides with an increment, and the mapping of each miscellaneous strobe.

// File: rtl/mac_stats_pkg.sv
package mac_stats_pkg;

    localparam int NUM_WORDS     = 32;
    localparam int MISC_W        = 14;

    // Word map, fixed because software decodes it
    localparam int W_RX_OCT_LO   = 0;
    localparam int W_RX_OCT_HI   = 1;
    localparam int W_RX_BAD_OCT  = 2;
    localparam int W_RX_GOOD_FRM = 4;
    localparam int W_RX_BAD_FRM  = 5;
    localparam int W_RX_BCAST    = 6;
    localparam int W_RX_MCAST    = 7;
    localparam int W_BIN_BASE    = 8;
    localparam int NUM_BINS      = 6;
    localparam int W_TX_OCT_LO   = 14;
    localparam int W_TX_OCT_HI   = 15;
    localparam int W_TX_FRM      = 16;
    localparam int W_TX_MCAST    = 18;
    localparam int W_TX_BCAST    = 19;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    // Destination word of miscellaneous strobe k
    function automatic int misc_word(input int k);
        if (k == 0)      return 3;
        else if (k == 1) return 17;
        else             return 18 + k;
    endfunction

endpackage

// File: rtl/stat_event_decode.sv
module stat_event_decode
    import mac_stats_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             rx_done,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_ok,
    input  logic             rx_bcast,
    input  logic             rx_mcast,
    input  logic             tx_done,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_bcast,
    input  logic             tx_mcast,
    input  logic [MISC_W-1:0] misc_evt,
    output logic [LEN_W-1:0] amt [NUM_WORDS]
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [2:0] bin_idx;

    // Length bin of a good received frame
    always_comb begin
        if (rx_len <= LEN_W'(64))        bin_idx = 3'd0;
        else if (rx_len <= LEN_W'(127))  bin_idx = 3'd1;
        else if (rx_len <= LEN_W'(255))  bin_idx = 3'd2;
        else if (rx_len <= LEN_W'(511))  bin_idx = 3'd3;
        else if (rx_len <= LEN_W'(1023)) bin_idx = 3'd4;
        else                             bin_idx = 3'd5;
    end

    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            amt[w] = '0;
        end
        if (rx_done) begin
            if (rx_ok) begin
                amt[W_RX_OCT_LO]   = rx_len;
                amt[W_RX_GOOD_FRM] = ONE;
                amt[W_BIN_BASE + int'(bin_idx)] = ONE;
                if (rx_bcast) amt[W_RX_BCAST] = ONE;
                if (rx_mcast) amt[W_RX_MCAST] = ONE;
            end else begin
                amt[W_RX_BAD_OCT] = rx_len;
                amt[W_RX_BAD_FRM] = ONE;
            end
        end
        if (tx_done) begin
            amt[W_TX_OCT_LO] = tx_len;
            amt[W_TX_FRM]    = ONE;
            if (tx_mcast) amt[W_TX_MCAST] = ONE;
            if (tx_bcast) amt[W_TX_BCAST] = ONE;
        end
        for (int k = 0; k < MISC_W; k++) begin
            if (misc_evt[k]) amt[misc_word(k)] = ONE;
        end
    end

endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LEN_W-1:0] amt,
    output logic [CNT_W-1:0] value
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    // A read clears first, then the same-cycle increment lands
    always_comb begin
        base = clr ? '0 : cnt;
        sum  = {1'b0, base} + (CNT_W+1)'(amt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    assign value = cnt;

endmodule

// File: rtl/stat_wide_counter.sv
module stat_wide_counter #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_lo,
    input  logic             clr_hi,
    input  logic [LEN_W-1:0] amt,
    output logic [CNT_W-1:0] lo_val,
    output logic [CNT_W-1:0] hi_val
);

    localparam int WIDE_W = 2 * CNT_W;

    logic [WIDE_W-1:0] total;
    logic [CNT_W-1:0]  snap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
            snap  <= '0;
        end else begin
            total <= (clr_lo ? '0 : total) + WIDE_W'(amt);
            if (clr_lo) begin
                snap <= total[WIDE_W-1:CNT_W];
            end else if (clr_hi) begin
                snap <= '0;
            end
        end
    end

    assign lo_val = total[CNT_W-1:0];
    assign hi_val = snap;

endmodule

// File: rtl/mac_stats_bank.sv
module mac_stats_bank
    import mac_stats_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16,
    localparam int ADDR_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_ok,
    input  logic              rx_bcast,
    input  logic              rx_mcast,
    input  logic              tx_done,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_bcast,
    input  logic              tx_mcast,
    input  logic [MISC_W-1:0] misc_evt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data
);

    logic [LEN_W-1:0]     amt      [NUM_WORDS];
    logic [CNT_W-1:0]     word_val [NUM_WORDS];
    logic [NUM_WORDS-1:0] rd_hit;
    rd_state_e            state, state_nxt;

    stat_event_decode #(.LEN_W(LEN_W)) u_decode (
        .rx_done  (rx_done),
        .rx_len   (rx_len),
        .rx_ok    (rx_ok),
        .rx_bcast (rx_bcast),
        .rx_mcast (rx_mcast),
        .tx_done  (tx_done),
        .tx_len   (tx_len),
        .tx_bcast (tx_bcast),
        .tx_mcast (tx_mcast),
        .misc_evt (misc_evt),
        .amt      (amt)
    );

    always_comb begin
        rd_hit = '0;
        if (rd_en) rd_hit[rd_addr] = 1'b1;
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == W_RX_OCT_LO || i == W_TX_OCT_LO) begin : g_wide
            stat_wide_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_lo (rd_hit[i]),
                .clr_hi (rd_hit[i+1]),
                .amt    (amt[i]),
                .lo_val (word_val[i]),
                .hi_val (word_val[i+1])
            );
        end else if (i == W_RX_OCT_HI || i == W_TX_OCT_HI) begin : g_hi
            // served by the wide counter of the word below
        end else begin : g_sat
            stat_sat_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (rd_hit[i]),
                .amt   (amt[i]),
                .value (word_val[i])
            );
        end
    end

    // Read machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_IDLE: if (rd_en)  state_nxt = RD_RESP;
            RD_RESP: if (!rd_en) state_nxt = RD_IDLE;
        endcase
    end

    // Read machine: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_en ? word_val[rd_addr] : '0;
    end

    assign rd_valid = (state == RD_RESP);

endmodule

// File: rtl/mac_stats_bank_chk.sv
module mac_stats_bank_chk
    import mac_stats_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic              tx_done,
    input logic [MISC_W-1:0] misc_evt,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [CNT_W-1:0]  rd_data
);

    // R2
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    // R3
    reread_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_done && !tx_done && misc_evt == '0)
        ##1 (rd_en && $stable(rd_addr)) |=> rd_data == '0);

endmodule

bind mac_stats_bank mac_stats_bank_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_done  (rx_done),
    .tx_done  (tx_done),
    .misc_evt (misc_evt),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/mac_stats_bank_tb.sv
module mac_stats_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_done = 0, rx_ok = 0, rx_bcast = 0, rx_mcast = 0;
    logic [15:0] rx_len = '0;
    logic        tx_done = 0, tx_bcast = 0, tx_mcast = 0;
    logic [15:0] tx_len = '0;
    logic [13:0] misc_evt = '0;
    logic        rd_en = 0;
    logic [4:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // pending event for the next step
    bit          e_rx, e_ok, e_rb, e_rm, e_tx, e_tb, e_tm;
    int          e_rlen, e_tlen;
    logic [13:0] e_misc;

    longint unsigned mdl  [32];
    longint unsigned snap [32];
    longint unsigned last_rd;

    always #4 clk = ~clk;

    mac_stats_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_done(rx_done), .rx_len(rx_len), .rx_ok(rx_ok),
        .rx_bcast(rx_bcast), .rx_mcast(rx_mcast),
        .tx_done(tx_done), .tx_len(tx_len),
        .tx_bcast(tx_bcast), .tx_mcast(tx_mcast),
        .misc_evt(misc_evt), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int bin_of(input int len);
        if (len <= 64)   return 8;
        if (len <= 127)  return 9;
        if (len <= 255)  return 10;
        if (len <= 511)  return 11;
        if (len <= 1023) return 12;
        return 13;
    endfunction

    function automatic int misc_dst(input int k);
        return (k == 0) ? 3 : (k == 1) ? 17 : 18 + k;
    endfunction

    function automatic void add32(input int w, input longint unsigned a);
        mdl[w] = (mdl[w] + a > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : mdl[w] + a;
    endfunction

    function automatic void model_events();
        if (e_rx) begin
            if (e_ok) begin
                mdl[0] += longint'(e_rlen);
                add32(4, 1);
                add32(bin_of(e_rlen), 1);
                if (e_rb) add32(6, 1);
                if (e_rm) add32(7, 1);
            end else begin
                add32(2, longint'(e_rlen));
                add32(5, 1);
            end
        end
        if (e_tx) begin
            mdl[14] += longint'(e_tlen);
            add32(16, 1);
            if (e_tm) add32(18, 1);
            if (e_tb) add32(19, 1);
        end
        for (int k = 0; k < 14; k++) if (e_misc[k]) add32(misc_dst(k), 1);
    endfunction

    function automatic void clr_ev();
        e_rx = 0; e_ok = 0; e_rb = 0; e_rm = 0; e_tx = 0; e_tb = 0; e_tm = 0;
        e_rlen = 0; e_tlen = 0; e_misc = '0;
    endfunction

    // One cycle: optional read of word w plus the pending events
    task automatic step(input bit rd, input int w, input string tag);
        longint unsigned exp_v = 0;
        rd_en = rd; rd_addr = 5'(w);
        rx_done = e_rx; rx_ok = e_ok; rx_bcast = e_rb; rx_mcast = e_rm; rx_len = 16'(e_rlen);
        tx_done = e_tx; tx_bcast = e_tb; tx_mcast = e_tm; tx_len = 16'(e_tlen);
        misc_evt = e_misc;
        if (rd) begin
            if (w == 0 || w == 14) begin
                exp_v = mdl[w] & 64'hFFFF_FFFF;
                snap[w+1] = mdl[w] >> 32;
                mdl[w] = 0;
            end else if (w == 1 || w == 15) begin
                exp_v = snap[w]; snap[w] = 0;
            end else begin
                exp_v = mdl[w]; mdl[w] = 0;
            end
        end
        model_events();
        @(posedge clk); @(negedge clk);
        rd_en = 0; rx_done = 0; tx_done = 0; misc_evt = '0;
        rx_ok = 0; rx_bcast = 0; rx_mcast = 0; tx_bcast = 0; tx_mcast = 0;
        clr_ev();
        if (rd) begin
            check(tag, longint'(rd_valid), 1);
            check(tag, longint'(rd_data), exp_v);
            last_rd = longint'(rd_data);
        end
    endtask

    task automatic rx_frame(input int len, input bit ok, input bit b, input bit m);
        e_rx = 1; e_ok = ok; e_rlen = len; e_rb = b; e_rm = m;
        step(0, 0, "R6");
    endtask

    task automatic tx_frame(input int len, input bit b, input bit m);
        e_tx = 1; e_tlen = len; e_tb = b; e_tm = m;
        step(0, 0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 32; w++) begin mdl[w] = 0; snap[w] = 0; end
        clr_ev();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", longint'(rd_valid), 0);
        check("R1 data", longint'(rd_data), 0);
        for (int w = 0; w < 32; w++) step(1, w, "R1");
        // R2 idle after a read
        @(negedge clk);
        check("R2 valid", longint'(rd_valid), 0);
        check("R2 data", longint'(rd_data), 0);

        // R6 good receive frames
        rx_frame(100, 1, 1, 0);
        rx_frame(64, 1, 0, 1);
        rx_frame(1500, 1, 0, 0);
        step(1, 0, "R6"); check("R6 octets", last_rd, 1664);
        step(1, 1, "R6");
        step(1, 4, "R6"); check("R6 frames", last_rd, 3);
        step(1, 6, "R6"); step(1, 7, "R6");
        // R3 reread returns zero
        step(1, 4, "R3"); check("R3 reread", last_rd, 0);

        // R4 read colliding with an increment
        rx_frame(70, 1, 0, 0); rx_frame(70, 1, 0, 0); rx_frame(70, 1, 0, 0);
        e_rx = 1; e_ok = 1; e_rlen = 80;
        step(1, 4, "R4"); check("R4 old", last_rd, 3);
        step(1, 4, "R4"); check("R4 restart", last_rd, 1);
        for (int w = 0; w < 32; w++) step(1, w, "R3");

        // R7 length sweep 1..1100
        for (int len = 1; len <= 1100; len++) rx_frame(len, 1, len % 3 == 0, len % 5 == 0);
        step(1, 8, "R7");  check("R7 bin64", last_rd, 64);
        step(1, 9, "R7");  check("R7 bin127", last_rd, 63);
        step(1, 10, "R7"); check("R7 bin255", last_rd, 128);
        step(1, 11, "R7"); check("R7 bin511", last_rd, 256);
        step(1, 12, "R7"); check("R7 bin1023", last_rd, 512);
        step(1, 13, "R7"); check("R7 bin1024", last_rd, 77);
        step(1, 0, "R6");  check("R6 sum", last_rd, 605550);
        step(1, 6, "R6");  check("R6 bcast", last_rd, 366);
        step(1, 7, "R6");  check("R6 mcast", last_rd, 220);

        // R8 bad frames
        rx_frame(50, 0, 1, 1); rx_frame(70, 0, 0, 0);
        step(1, 2, "R8"); check("R8 octets", last_rd, 120);
        step(1, 5, "R8"); check("R8 frames", last_rd, 2);
        for (int w = 0; w < 32; w++) step(1, w, "R8");

        // R10 transmit
        tx_frame(200, 1, 0); tx_frame(300, 0, 1); tx_frame(60, 0, 0);
        step(1, 14, "R10"); check("R10 octets", last_rd, 560);
        step(1, 15, "R10");
        step(1, 16, "R10"); check("R10 frames", last_rd, 3);
        step(1, 18, "R10"); check("R10 mcast", last_rd, 1);
        step(1, 19, "R10"); check("R10 bcast", last_rd, 1);

        // R11 misc strobes: bit k pulsed k+1 times
        for (int k = 0; k < 14; k++)
            for (int n = 0; n <= k; n++) begin e_misc = 14'(1 << k); step(0, 0, "R11"); end
        for (int k = 0; k < 14; k++) begin
            step(1, misc_dst(k), "R11");
            check("R11 count", last_rd, longint'(k + 1));
        end

        // R5 and R9: drive totals to 2^32-1, then one more byte
        for (int n = 0; n < 65537; n++) begin
            e_rx = 1; e_ok = 0; e_rlen = 65535; e_tx = 1; e_tlen = 65535;
            step(0, 0, "R5");
        end
        e_rx = 1; e_ok = 0; e_rlen = 1; e_tx = 1; e_tlen = 1;
        step(0, 0, "R5");
        step(1, 2, "R5");  check("R5 saturate", last_rd, 64'hFFFF_FFFF);
        step(1, 5, "R5");  check("R5 frames", last_rd, 65538);
        step(1, 16, "R10"); check("R10 many", last_rd, 65538);
        step(1, 14, "R9"); check("R9 low", last_rd, 0);
        tx_frame(5, 0, 0);
        step(1, 15, "R9"); check("R9 snapshot", last_rd, 1);
        step(1, 15, "R9"); check("R9 snap clear", last_rd, 0);
        step(1, 14, "R9"); check("R9 new low", last_rd, 5);

        // final sweep twice
        for (int w = 0; w < 32; w++) step(1, w, "R3");
        for (int w = 0; w < 32; w++) begin
            step(1, w, "R3"); check("R3 empty", last_rd, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule